// File: doc/BRIEF.md
# PLL Retune Sequencer

This block moves a fractional-capable PLL to a new frequency without glitching the clock it feeds. A single start pulse captures a feedback integer value (12 bits), a feedback fraction (24 bits), a reference divider value and a bypass-only flag. The sequencer then talks to the PLL's register file over a simple single-outstanding bus master port, where a request is held until `bus_ready` is sampled high. It unlocks the register file with two keys and parks the output on the glitchless bypass path. It shuts the PLL off and programs the dividers and the control word, then prepares calibration. Finally it turns the PLL on, polls for lock and, where it applies, for calibration lock, and only then releases bypass. On a calibration-lock timeout it falls back to running without calibration. A lock failure leaves the output in bypass and is reported with `fail`.

States: IDLE, KEY0, KEY1 (unlock writes), CTRL_RD, BYP_SET, DIS_WR (bypass and disable), CFG_RD, DIV_RD, INT_WR, FRAC_WR, DIV_WR, CTRL_WR (programming), CALQ_RD, CAL1_WR, CAL2_WR, CALOFF_WR, CALOFF_POLL (calibration), EN_WR, WAIT, LOCK_POLL, CALEN_RD, CLOCK_POLL (enable and lock), REL_WR (bypass release) and FIN (one-cycle done). Transitions:
- IDLE→KEY0 on start.
- CTRL_RD→BYP_SET when bypass is clear.
- →DIS_WR when the enable is set.
- →FIN after the disable in bypass-only mode.
- CTRL_WR→CALQ_RD for type 1, else through WAIT to EN_WR.
- CALQ_RD→CAL1_WR (integer) or →CALOFF_WR (fraction or recovery).
- LOCK_POLL→CALEN_RD / REL_WR on lock, →FIN with error on timeout.
- CLOCK_POLL→REL_WR on calibration lock, →DIS_WR (recovery) on timeout.
- WAIT returns to the state it was given after `US_CYCLES` cycles.

Top module: `pll_seq`

## Requirements
- R1: Every run begins with two writes: 32'h68EF3490 to the first key offset, then the `KEY1` parameter to the second key offset.
- R2: The control register is read; only if its bit 31 (bypass) is clear is it written back with bit 31 set; only if its bit 15 (PLL enable) is set is it then written with bit 15 cleared, followed by a wait of `US_CYCLES` cycles.
- R3: With `bypass_only` set, the run ends right after the disable step: no further writes, bypass left set, done without fail.
- R4: The feedback integer is written zero-extended to the integer offset, then the fraction zero-extended to the fraction offset, then the divider register read earlier with bits REF_W-1:0 replaced by `ref_div` and all other bits kept.
- R5: The PLL type is bits 1:0 of the config register. The control word written next keeps every other bit but clears bits 8 and 5 and sets bits 4 and 16. For type 0 it sets bits 1:0; for type 1 it sets bits 1:0 if the fraction is nonzero and clears them otherwise.
- R6: For type 1 with zero fraction, the calibration control register is written with bit 30 (fast mode) set, bit 15 cleared, bits 18:16 = 2 and bits 11:0 = 0; at least `US_CYCLES` cycles later it is written again with bit 31 (enable) added.
- R7: For type 1 with nonzero fraction, calibration control is written with bit 31 cleared, then the calibration status is read until its bit 31 is low.
- R8: The enable write (control bit 15 set) comes at least `US_CYCLES` cycles after the previous configuration write. Status bit 0 is then polled at most `LOCK_TRIES` times; if lock never shows, done and fail rise together and no bypass release is written.
- R9: Calibration status bit 31 is polled, at most `CAL_TRIES` times, only for type 1 with zero fraction when calibration control bit 31 reads back set; otherwise the sequencer goes straight to release after lock.
- R10: On a calibration-lock timeout the sequencer writes the PLL disabled, clears calibration enable and waits for calibration status low, writes the PLL enabled, and polls lock again; fail is raised only if that lock also times out.
- R11: A successful run ends with one control write that clears only bit 31, then a one-cycle done pulse with fail low.
- R12: Only one of `bus_we`/`bus_re` is high at a time, and a request keeps its address and write data until `bus_ready`.
- R13: A start pulse while busy is ignored: the run in progress is unchanged and produces exactly one done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a retune run (sampled in IDLE) |
| fb_int | input | 12 | Feedback integer divider |
| fb_frac | input | 24 | Feedback fractional divider |
| ref_div | input | REF_W | Reference divider |
| bypass_only | input | 1 | Stop after bypass and disable |
| bus_addr | output | AW | Register offset |
| bus_wdata | output | 32 | Write data |
| bus_we | output | 1 | Write request |
| bus_re | output | 1 | Read request |
| bus_rdata | input | 32 | Read data, valid with bus_ready |
| bus_ready | input | 1 | Completes the current request |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | High with done when lock was not reached |

## Verification
The bench predicts the exact write stream for each run and checks that bypass is only ever written when clear and that the disable is only written when the PLL was running. A design that rewrote either would emit extra writes. It drives a calibration-lock timeout and confirms the exact number of status reads and the recovery writes. A design with an off-by-one poll limit, or one that skipped recovery, would show a wrong read count or would release bypass early. It also covers a lock timeout, which must leave the control register with bypass set, and a calibration enable that reads back clear, which must skip the calibration-lock wait entirely. A mid-run start pulse with different divider values catches a design that restarts or relatches.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
    // Control register bit positions
    localparam int CB_BYP     = 31;
    localparam int CB_LOSS    = 16;
    localparam int CB_EN      = 15;
    localparam int CB_INT_BYP = 8;
    localparam int CB_QUAD    = 5;
    localparam int CB_POST    = 4;
    localparam int CB_DSM     = 1;
    localparam int CB_DAC     = 0;
    // Status / calibration bit positions
    localparam int STAT_LOCK  = 0;
    localparam int CAL_LOCK   = 31;
    localparam int CAL_NOBYP  = 15;
    localparam logic [31:0] KEY0 = 32'h68EF_3490;

    typedef enum logic [4:0] {
        S_IDLE, S_KEY0, S_KEY1, S_CTRL_RD, S_BYP_SET, S_DIS_WR,
        S_CFG_RD, S_DIV_RD, S_INT_WR, S_FRAC_WR, S_DIV_WR, S_CTRL_WR,
        S_CALQ_RD, S_CAL1_WR, S_CAL2_WR, S_CALOFF_WR, S_CALOFF_POLL,
        S_EN_WR, S_WAIT, S_LOCK_POLL, S_CALEN_RD, S_CLOCK_POLL,
        S_REL_WR, S_FIN
    } seq_state_t;
endpackage

// File: rtl/pll_seq_count.sv
module pll_seq_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pll_seq_words.sv
module pll_seq_words
    import pll_seq_pkg::*;
#(
    parameter int FAST_BIT = 30
) (
    input  logic [31:0] ctrl_old,
    input  logic [1:0]  pll_type,
    input  logic        frac_nz,
    input  logic [31:0] cal_old,
    output logic [31:0] ctrl_cfg,
    output logic [31:0] cal_step1
);
    always_comb begin
        ctrl_cfg             = ctrl_old;
        ctrl_cfg[CB_INT_BYP] = 1'b0;
        ctrl_cfg[CB_QUAD]    = 1'b0;
        ctrl_cfg[CB_POST]    = 1'b1;
        ctrl_cfg[CB_LOSS]    = 1'b1;
        if (pll_type == 2'd0) begin
            ctrl_cfg[CB_DSM] = 1'b1;
            ctrl_cfg[CB_DAC] = 1'b1;
        end else if (pll_type == 2'd1) begin
            ctrl_cfg[CB_DSM] = frac_nz;
            ctrl_cfg[CB_DAC] = frac_nz;
        end

        cal_step1            = cal_old;
        cal_step1[FAST_BIT]  = 1'b1;
        cal_step1[CAL_NOBYP] = 1'b0;
        cal_step1[18:16]     = 3'd2;
        cal_step1[11:0]      = 12'd0;
    end
endmodule

// File: rtl/pll_seq.sv
module pll_seq
    import pll_seq_pkg::*;
#(
    parameter int AW         = 12,
    parameter int REF_W      = 6,
    parameter int US_CYCLES  = 100,
    parameter int LOCK_TRIES = 15000,
    parameter int CAL_TRIES  = 435000,
    parameter int CALEN_BIT  = 31,
    parameter int FAST_BIT   = 30,
    parameter logic [31:0]   KEY1     = 32'hD172_BC5A,
    parameter logic [AW-1:0] OFS_KEY0 = 'h010,
    parameter logic [AW-1:0] OFS_KEY1 = 'h014,
    parameter logic [AW-1:0] OFS_CFG  = 'h008,
    parameter logic [AW-1:0] OFS_CTRL = 'h020,
    parameter logic [AW-1:0] OFS_STAT = 'h024,
    parameter logic [AW-1:0] OFS_INT  = 'h030,
    parameter logic [AW-1:0] OFS_FRAC = 'h034,
    parameter logic [AW-1:0] OFS_DIV  = 'h038,
    parameter logic [AW-1:0] OFS_CALC = 'h060,
    parameter logic [AW-1:0] OFS_CALS = 'h064
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [11:0]      fb_int,
    input  logic [23:0]      fb_frac,
    input  logic [REF_W-1:0] ref_div,
    input  logic             bypass_only,
    output logic [AW-1:0]    bus_addr,
    output logic [31:0]      bus_wdata,
    output logic             bus_we,
    output logic             bus_re,
    input  logic [31:0]      bus_rdata,
    input  logic             bus_ready,
    output logic             busy,
    output logic             done,
    output logic             fail
);
    localparam int MAX_A = (LOCK_TRIES > CAL_TRIES) ? LOCK_TRIES : CAL_TRIES;
    localparam int MAX_C = (MAX_A > US_CYCLES) ? MAX_A : US_CYCLES;
    localparam int CW    = $clog2(MAX_C + 1);
    localparam logic [31:0] M_BYP = 32'h1 << CB_BYP;
    localparam logic [31:0] M_EN  = 32'h1 << CB_EN;
    localparam logic [31:0] M_CAL = 32'h1 << CALEN_BIT;

    seq_state_t st, nxt, ret_q, ret_d;
    logic [11:0]      int_q;
    logic [23:0]      frac_q;
    logic [REF_W-1:0] ref_q;
    logic             byp_only_q, recov_q, err_q;
    logic [1:0]       type_q;
    logic [31:0]      ctrl_q, cal_q, ctrl_cfg, cal_step1;
    logic [31:REF_W]  div_hi_q;
    logic [CW-1:0]    cnt;
    logic             cnt_clr, cnt_inc, frac_nz, cal_int;
    seq_state_t       dis_tgt;

    assign frac_nz = |frac_q;
    assign cal_int = (type_q == 2'd1) && !frac_nz;
    assign dis_tgt = byp_only_q ? S_FIN : (recov_q ? S_CALQ_RD : S_CFG_RD);

    pll_seq_count #(.W(CW)) i_count (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc), .cnt(cnt)
    );

    pll_seq_words #(.FAST_BIT(FAST_BIT)) i_words (
        .ctrl_old(ctrl_q), .pll_type(type_q), .frac_nz(frac_nz),
        .cal_old(cal_q), .ctrl_cfg(ctrl_cfg), .cal_step1(cal_step1)
    );

    // Next state
    always_comb begin
        nxt     = st;
        ret_d   = ret_q;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        unique case (st)
            S_IDLE:    begin cnt_clr = 1'b1; if (start) nxt = S_KEY0; end
            S_KEY0:    if (bus_ready) nxt = S_KEY1;
            S_KEY1:    if (bus_ready) nxt = S_CTRL_RD;
            S_CTRL_RD: if (bus_ready) begin
                if (!bus_rdata[CB_BYP])    nxt = S_BYP_SET;
                else if (bus_rdata[CB_EN]) nxt = S_DIS_WR;
                else                       nxt = dis_tgt;
            end
            S_BYP_SET: if (bus_ready) nxt = ctrl_q[CB_EN] ? S_DIS_WR : dis_tgt;
            S_DIS_WR:  if (bus_ready) begin nxt = S_WAIT; ret_d = dis_tgt; end
            S_CFG_RD:  if (bus_ready) nxt = S_DIV_RD;
            S_DIV_RD:  if (bus_ready) nxt = S_INT_WR;
            S_INT_WR:  if (bus_ready) nxt = S_FRAC_WR;
            S_FRAC_WR: if (bus_ready) nxt = S_DIV_WR;
            S_DIV_WR:  if (bus_ready) nxt = S_CTRL_WR;
            S_CTRL_WR: if (bus_ready) begin
                if (type_q == 2'd1) nxt = S_CALQ_RD;
                else begin nxt = S_WAIT; ret_d = S_EN_WR; end
            end
            S_CALQ_RD:   if (bus_ready) nxt = (recov_q || frac_nz) ? S_CALOFF_WR : S_CAL1_WR;
            S_CAL1_WR:   if (bus_ready) begin nxt = S_WAIT; ret_d = S_CAL2_WR; end
            S_CAL2_WR:   if (bus_ready) begin nxt = S_WAIT; ret_d = S_EN_WR; end
            S_CALOFF_WR: if (bus_ready) nxt = S_CALOFF_POLL;
            S_CALOFF_POLL:
                if (bus_ready && !bus_rdata[CAL_LOCK]) begin nxt = S_WAIT; ret_d = S_EN_WR; end
            S_EN_WR:   if (bus_ready) begin nxt = S_WAIT; ret_d = S_LOCK_POLL; end
            S_WAIT: begin
                cnt_inc = 1'b1;
                if (cnt == CW'(US_CYCLES - 1)) begin nxt = ret_q; cnt_clr = 1'b1; end
            end
            S_LOCK_POLL: if (bus_ready) begin
                if (bus_rdata[STAT_LOCK]) begin
                    cnt_clr = 1'b1;
                    nxt = (cal_int && !recov_q) ? S_CALEN_RD : S_REL_WR;
                end else if (cnt == CW'(LOCK_TRIES - 1)) begin
                    cnt_clr = 1'b1; nxt = S_FIN;
                end else cnt_inc = 1'b1;
            end
            S_CALEN_RD: if (bus_ready) nxt = bus_rdata[CALEN_BIT] ? S_CLOCK_POLL : S_REL_WR;
            S_CLOCK_POLL: if (bus_ready) begin
                if (bus_rdata[CAL_LOCK]) begin
                    cnt_clr = 1'b1; nxt = S_REL_WR;
                end else if (cnt == CW'(CAL_TRIES - 1)) begin
                    cnt_clr = 1'b1; nxt = S_DIS_WR;
                end else cnt_inc = 1'b1;
            end
            S_REL_WR: if (bus_ready) nxt = S_FIN;
            S_FIN:    nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= S_IDLE;
            ret_q <= S_IDLE;
        end else begin
            st    <= nxt;
            ret_q <= ret_d;
        end
    end

    // Captured values and shadows
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_q <= '0; frac_q <= '0; ref_q <= '0; byp_only_q <= 1'b0;
            recov_q <= 1'b0; err_q <= 1'b0; type_q <= '0;
            ctrl_q <= '0; cal_q <= '0; div_hi_q <= '0;
        end else begin
            if (st == S_IDLE && start) begin
                int_q <= fb_int; frac_q <= fb_frac; ref_q <= ref_div;
                byp_only_q <= bypass_only; recov_q <= 1'b0; err_q <= 1'b0;
            end
            if (bus_ready && bus_re) begin
                if (st == S_CTRL_RD) ctrl_q   <= bus_rdata;
                if (st == S_CFG_RD)  type_q   <= bus_rdata[1:0];
                if (st == S_DIV_RD)  div_hi_q <= bus_rdata[31:REF_W];
                if (st == S_CALQ_RD) cal_q    <= bus_rdata;
            end
            if (bus_ready && bus_we && bus_addr == OFS_CTRL) ctrl_q <= bus_wdata;
            if (bus_ready && bus_we && bus_addr == OFS_CALC) cal_q  <= bus_wdata;
            if (st == S_LOCK_POLL && bus_ready && !bus_rdata[STAT_LOCK] &&
                cnt == CW'(LOCK_TRIES - 1)) err_q <= 1'b1;
            if (st == S_CLOCK_POLL && bus_ready && !bus_rdata[CAL_LOCK] &&
                cnt == CW'(CAL_TRIES - 1)) recov_q <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        bus_addr  = '0;
        bus_wdata = '0;
        bus_we    = 1'b0;
        bus_re    = 1'b0;
        unique case (st)
            S_KEY0:      begin bus_we = 1'b1; bus_addr = OFS_KEY0; bus_wdata = KEY0; end
            S_KEY1:      begin bus_we = 1'b1; bus_addr = OFS_KEY1; bus_wdata = KEY1; end
            S_CTRL_RD:   begin bus_re = 1'b1; bus_addr = OFS_CTRL; end
            S_BYP_SET:   begin bus_we = 1'b1; bus_addr = OFS_CTRL; bus_wdata = ctrl_q | M_BYP; end
            S_DIS_WR:    begin bus_we = 1'b1; bus_addr = OFS_CTRL; bus_wdata = ctrl_q & ~M_EN; end
            S_CFG_RD:    begin bus_re = 1'b1; bus_addr = OFS_CFG; end
            S_DIV_RD:    begin bus_re = 1'b1; bus_addr = OFS_DIV; end
            S_INT_WR:    begin bus_we = 1'b1; bus_addr = OFS_INT;  bus_wdata = {20'd0, int_q}; end
            S_FRAC_WR:   begin bus_we = 1'b1; bus_addr = OFS_FRAC; bus_wdata = {8'd0, frac_q}; end
            S_DIV_WR:    begin bus_we = 1'b1; bus_addr = OFS_DIV;  bus_wdata = {div_hi_q, ref_q}; end
            S_CTRL_WR:   begin bus_we = 1'b1; bus_addr = OFS_CTRL; bus_wdata = ctrl_cfg; end
            S_CALQ_RD,
            S_CALEN_RD:  begin bus_re = 1'b1; bus_addr = OFS_CALC; end
            S_CAL1_WR:   begin bus_we = 1'b1; bus_addr = OFS_CALC; bus_wdata = cal_step1; end
            S_CAL2_WR:   begin bus_we = 1'b1; bus_addr = OFS_CALC; bus_wdata = cal_q | M_CAL; end
            S_CALOFF_WR: begin bus_we = 1'b1; bus_addr = OFS_CALC; bus_wdata = cal_q & ~M_CAL; end
            S_CALOFF_POLL,
            S_CLOCK_POLL: begin bus_re = 1'b1; bus_addr = OFS_CALS; end
            S_EN_WR:     begin bus_we = 1'b1; bus_addr = OFS_CTRL; bus_wdata = ctrl_q | M_EN; end
            S_LOCK_POLL: begin bus_re = 1'b1; bus_addr = OFS_STAT; end
            S_REL_WR:    begin bus_we = 1'b1; bus_addr = OFS_CTRL; bus_wdata = ctrl_q & ~M_BYP; end
            default: ;
        endcase
    end

    assign busy = (st != S_IDLE);
    assign done = (st == S_FIN);
    assign fail = (st == S_FIN) && err_q;

    // Assertions
    a_r12_one_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_re));
    a_r12_hold_wr: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !bus_ready) |=> (bus_we && $stable(bus_addr) && $stable(bus_wdata)));
    a_r12_hold_rd: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && !bus_ready) |=> (bus_re && $stable(bus_addr)));
    a_r13_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(int_q) && $stable(frac_q) && $stable(ref_q)));
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r11_release_when_on: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_CTRL && !bus_wdata[CB_BYP]) |-> ctrl_q[CB_EN]);
    a_r8_fail_in_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> ctrl_q[CB_BYP]);
    a_r5_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_CTRL_WR && bus_we) |-> (bus_wdata[CB_POST] && bus_wdata[CB_LOSS] &&
                                         !bus_wdata[CB_INT_BYP] && !bus_wdata[CB_QUAD]));
endmodule

// File: tb/test_pll_seq.sv
module test_pll_seq;
    localparam int CLK_P = 10;
    localparam int US = 4, LT = 20, CT = 30;
    localparam logic [11:0] O_K0 = 12'h010, O_K1 = 12'h014, O_CFG = 12'h008,
        O_CTRL = 12'h020, O_STAT = 12'h024, O_F0 = 12'h030, O_F1 = 12'h034,
        O_DIV = 12'h038, O_CC = 12'h060, O_CS = 12'h064;
    localparam logic [31:0] K0 = 32'h68EF_3490, K1 = 32'h5A5A_1234;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, bypass_only = 1'b0;
    logic [11:0] fb_int = '0;
    logic [23:0] fb_frac = '0;
    logic [5:0]  ref_div = '0;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic bus_we, bus_re, bus_ready, busy, done, fail;

    always #(CLK_P/2) clk = ~clk;

    pll_seq #(.AW(12), .REF_W(6), .US_CYCLES(US), .LOCK_TRIES(LT), .CAL_TRIES(CT),
        .KEY1(K1), .OFS_KEY0(O_K0), .OFS_KEY1(O_K1), .OFS_CFG(O_CFG),
        .OFS_CTRL(O_CTRL), .OFS_STAT(O_STAT), .OFS_INT(O_F0), .OFS_FRAC(O_F1),
        .OFS_DIV(O_DIV), .OFS_CALC(O_CC), .OFS_CALS(O_CS)) i_pll_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .fb_int(fb_int), .fb_frac(fb_frac),
        .ref_div(ref_div), .bypass_only(bypass_only), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .busy(busy), .done(done), .fail(fail));

    // Behavioural PLL register file
    logic [31:0] r_ctrl, r_f0, r_f1, r_div, r_cal;
    logic [1:0]  r_type = 2'd1;
    logic lock_ok = 1'b1, cal_ok = 1'b1, rb_zero = 1'b0;
    int n_stat = 0, n_cs = 0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_ready <= 1'b0;
            r_ctrl <= 32'h0000_0120; r_f0 <= '0; r_f1 <= '0;
            r_div <= 32'h00AB_0003; r_cal <= 32'h0005_8ABC;
        end else begin
            bus_ready <= (bus_we || bus_re) && !bus_ready;
            if (bus_ready && bus_we) begin
                case (bus_addr)
                    O_CTRL: r_ctrl <= bus_wdata;
                    O_F0:   r_f0 <= bus_wdata;
                    O_F1:   r_f1 <= bus_wdata;
                    O_DIV:  r_div <= bus_wdata;
                    O_CC:   r_cal <= bus_wdata;
                    default: ;
                endcase
            end
        end
    end
    always_ff @(posedge clk) begin
        if (bus_ready && bus_re && bus_addr == O_STAT) n_stat <= n_stat + 1;
        if (bus_ready && bus_re && bus_addr == O_CS)   n_cs <= n_cs + 1;
    end
    always_comb begin
        case (bus_addr)
            O_CTRL:  bus_rdata = r_ctrl;
            O_CFG:   bus_rdata = {30'h0ABC_DEF0, r_type};
            O_DIV:   bus_rdata = r_div;
            O_CC:    bus_rdata = rb_zero ? (r_cal & 32'h7FFF_FFFF) : r_cal;
            O_CS:    bus_rdata = {r_cal[31] && cal_ok && r_ctrl[15], 31'h0};
            O_STAT:  bus_rdata = {31'h0, r_ctrl[15] && lock_ok};
            default: bus_rdata = 32'hDEAD_BEEF;
        endcase
    end

    // Scoreboard
    int total = 0, bad = 0, cyc = 0, n_done = 0, n_wr = 0;
    bit finished = 1'b0;
    logic [11:0] q_a[$];
    logic [31:0] q_d[$];
    string       q_r[$];
    int          wr_cyc[int];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [11:0] a, input logic [31:0] d, input string r);
        q_a.push_back(a); q_d.push_back(d); q_r.push_back(r);
    endtask

    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) begin
        if (done) n_done++;
        if (bus_ready && bus_we) begin
            wr_cyc[n_wr] = cyc;
            n_wr++;
            if (q_a.size() == 0) chk(0, "R12", "unexpected write", {20'h0, bus_addr}, bus_wdata);
            else begin
                logic [11:0] ea; logic [31:0] ed; string er;
                ea = q_a.pop_front(); ed = q_d.pop_front(); er = q_r.pop_front();
                chk(bus_addr == ea, er, "write address", {20'h0, bus_addr}, {20'h0, ea});
                chk(bus_wdata == ed, er, "write data", bus_wdata, ed);
            end
        end
    end

    // Bench model of the stub contents
    logic [31:0] mc = 32'h0000_0120, md = 32'h00AB_0003, mcal = 32'h0005_8ABC;

    function automatic logic [31:0] cal1(input logic [31:0] v);
        return ((v | 32'h4000_0000) & ~32'h0007_8FFF) | 32'h0002_0000;
    endfunction

    task automatic plan(input logic [1:0] ty, input logic [11:0] iv, input logic [23:0] fv,
                        input logic [5:0] rv, input bit bo, output bit efail);
        bit wait_cal;
        logic [31:0] rd;
        efail = 0; wait_cal = 0;
        push(O_K0, K0, "R1"); push(O_K1, K1, "R1");
        if (!mc[31]) begin mc[31] = 1'b1; push(O_CTRL, mc, "R2"); end
        if (mc[15])  begin mc[15] = 1'b0; push(O_CTRL, mc, "R2"); end
        if (bo) return;
        push(O_F0, {20'h0, iv}, "R4"); push(O_F1, {8'h0, fv}, "R4");
        md = {md[31:6], rv}; push(O_DIV, md, "R4");
        mc[8] = 0; mc[5] = 0; mc[4] = 1; mc[16] = 1;
        if (ty == 2'd0) mc[1:0] = 2'b11;
        else if (ty == 2'd1) mc[1:0] = (fv != 0) ? 2'b11 : 2'b00;
        push(O_CTRL, mc, "R5");
        if (ty == 2'd1) begin
            rd = rb_zero ? (mcal & 32'h7FFF_FFFF) : mcal;
            if (fv != 0) begin mcal = rd & 32'h7FFF_FFFF; push(O_CC, mcal, "R7"); end
            else begin
                mcal = cal1(rd); push(O_CC, mcal, "R6");
                mcal[31] = 1'b1; push(O_CC, mcal, "R6");
                wait_cal = !rb_zero;
            end
        end
        mc[15] = 1'b1; push(O_CTRL, mc, "R8");
        if (!lock_ok) begin efail = 1; return; end
        if (wait_cal && !cal_ok) begin
            mc[15] = 1'b0; push(O_CTRL, mc, "R10");
            mcal[31] = 1'b0; push(O_CC, mcal, "R10");
            mc[15] = 1'b1; push(O_CTRL, mc, "R10");
        end
        mc[31] = 1'b0; push(O_CTRL, mc, "R11");
    endtask

    task automatic run(input string tag, input logic [1:0] ty, input logic [11:0] iv,
                       input logic [23:0] fv, input logic [5:0] rv, input bit bo,
                       input bit poke_busy);
        bit efail;
        int d0, guard;
        r_type = ty;
        plan(ty, iv, fv, rv, bo, efail);
        d0 = n_done;
        @(negedge clk);
        fb_int = iv; fb_frac = fv; ref_div = rv; bypass_only = bo; start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (poke_busy) begin
            repeat (9) @(negedge clk);
            fb_int = ~iv; fb_frac = ~fv; ref_div = ~rv; start = 1'b1;   // R13
            @(negedge clk); start = 1'b0;
        end
        guard = 0;
        while (!done && guard < 5000) begin @(negedge clk); guard++; end
        chk(done, tag, "done seen", {31'h0, done}, 32'h1);
        chk(fail == efail, efail ? "R8" : "R11", "fail with done", {31'h0, fail}, {31'h0, efail});
        repeat (6) @(negedge clk);
        chk(q_a.size() == 0, tag, "writes left unseen", q_a.size(), 0);
        chk(n_done - d0 == 1, "R13", "done pulses per run", n_done - d0, 1);
        chk(!busy, tag, "idle after run", {31'h0, busy}, 32'h0);
        q_a.delete(); q_d.delete(); q_r.delete();
    endtask

    initial begin
        int s, c0, c1;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !bus_we && !bus_re, "R12", "reset outputs",
            {28'h0, busy, done, bus_we, bus_re}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6: type 1 integer, calibration locks; busy start poke (R13)
        s = n_wr;
        run("R6", 2'd1, 12'h0C8, 24'h0, 6'd2, 1'b0, 1'b1);
        chk(wr_cyc[s+8] - wr_cyc[s+7] >= US, "R6", "gap between cal writes",
            wr_cyc[s+8] - wr_cyc[s+7], US);
        chk(wr_cyc[s+9] - wr_cyc[s+8] >= US, "R8", "gap before enable",
            wr_cyc[s+9] - wr_cyc[s+8], US);
        chk(r_f0 == 32'h0000_00C8, "R13", "integer kept from first start", r_f0, 32'h0C8);

        // R5: type 0 with fraction
        run("R5", 2'd0, 12'h064, 24'h12_3456, 6'd1, 1'b0, 1'b0);
        // R7: type 1 fractional, calibration turned off
        run("R7", 2'd1, 12'h050, 24'h80_0000, 6'd3, 1'b0, 1'b0);
        // R3: bypass only
        run("R3", 2'd1, 12'h010, 24'h0, 6'd1, 1'b1, 1'b0);
        chk(r_ctrl[31] && !r_ctrl[15], "R3", "bypass kept, pll off", r_ctrl, 32'h8000_0000);

        // R10: calibration lock never comes, recovery succeeds
        cal_ok = 1'b0;
        c0 = n_cs; c1 = n_stat;
        run("R10", 2'd1, 12'h0A0, 24'h0, 6'd4, 1'b0, 1'b0);
        chk(n_cs - c0 == CT + 1, "R9", "calibration status reads", n_cs - c0, CT + 1);
        chk(n_stat - c1 == 2, "R10", "lock reads incl. relock", n_stat - c1, 2);
        chk(!r_ctrl[31] && r_ctrl[15], "R10", "running after recovery", r_ctrl, 32'h0000_8000);

        // R8: lock never comes
        lock_ok = 1'b0; cal_ok = 1'b1;
        c1 = n_stat;
        run("R8", 2'd0, 12'h070, 24'h0, 6'd2, 1'b0, 1'b0);
        chk(n_stat - c1 == LT, "R8", "lock status reads", n_stat - c1, LT);
        chk(r_ctrl[31] == 1'b1, "R8", "bypass left on failure", r_ctrl, 32'h8000_0000);

        // R9: enable reads back clear -> no calibration-lock wait
        lock_ok = 1'b1; cal_ok = 1'b0; rb_zero = 1'b1;
        c0 = n_cs;
        run("R9", 2'd1, 12'h0B0, 24'h0, 6'd5, 1'b0, 1'b0);
        chk(n_cs - c0 == 0, "R9", "no calibration status reads", n_cs - c0, 0);
        chk(r_div == 32'h00AB_0005, "R4", "divider field merged", r_div, 32'h00AB_0005);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL R12 watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule